// File: doc/BRIEF.md
# Sub-Clock Interval Timer

This block divides a slow sub-clock, presented as a single-cycle tick enable in the system clock domain, with a free-running 15-bit binary counter. It raises an interval flag each time a chosen counter bit falls. Software picks one of four periods with a 2-bit selector. The counter advances only while a run bit is set. Software can zero the counter through a byte-wide control register. A watchdog reset pulse and the block reset also zero the counter.

The pending flag drives an interrupt line while the interrupt enable is set. Software acknowledges the flag by writing 0 to its bit. Writing 1 to it does nothing, so a read-modify-write of the other fields can keep an event that has not yet been serviced. The counter-clear bit acts on a written 0 and always reads back as 1. A hardware flag set beats a software acknowledge that lands in the same cycle. A counter clear also resets the edge history, so the clear never produces a flag on its own.

Top module: `subclk_interval_timer`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `rd_data` reads 8'h01 and `irq` is 0.
- R2: `rd_data` bit 7 is the flag, bit 6 the interrupt enable, bit 5 the run bit, bits 2:1 the period select, and bit 0 always reads 1. Bits 4:3 always read 0, and writing 1 to them changes nothing.
- R3: The counter advances by one at each clock edge where `tick` is 1 and the run bit is 1. While the run bit is 0 the counter holds its value, so no interval event occurs.
- R4: Select 00, 01, 10 and 11 give periods of 2^10, 2^13, 2^14 and 2^15 ticks. The flag is set at the clock edge after the edge where the counter reaches a nonzero multiple of the period, which is the falling edge of counter bit (log2 period − 1).
- R5: A write with bit 7 = 0 clears the flag. A write with bit 7 = 1 leaves the flag unchanged.
- R6: `irq` is 1 exactly when the flag and the interrupt enable are both 1. This includes the case where the enable is written to 1 while the flag is already pending.
- R7: A write with bit 0 = 0 zeroes the counter at that clock edge. A write with bit 0 = 1 leaves the counter alone.
- R8: A cycle with `wdog_rst` high zeroes the counter and leaves the flag, enable, run and select fields unchanged.
- R9: If an interval event and a flag-clearing write occur in the same cycle, the flag ends set.
- R10: A counter clear, by write or by watchdog, never sets the flag by itself, even when the selected counter bit was 1 before the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| tick | input | 1 | One-cycle enable at the sub-clock rate |
| wdog_rst | input | 1 | Watchdog reset pulse; zeroes the counter |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register read value |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is R9, where the interval event and the software acknowledge must fall in the same cycle. That cycle lasts one clock and is visible only two registers after the tick that causes it. The bench runs a behavioural model alongside the design and watches the model's counter and edge history. On the exact cycle the model shows the tap falling, the bench drives the clearing write in that same cycle. The no-spurious-set case (R10) is reached the same way: the bench waits until the model shows the selected bit high and then issues the clear.

// File: rtl/sit_pkg.sv
// Package: shared field positions and widths of the interval timer's
// control register. Assumes an 8-bit register with fixed bit roles.
package sit_pkg;
    localparam int REG_W      = 8;
    localparam int SEL_W      = 2;
    localparam int NUM_SEL    = 1 << SEL_W;
    localparam int BIT_FLAG   = 7;
    localparam int BIT_IE     = 6;
    localparam int BIT_RUN    = 5;
    localparam int BIT_RSV_HI = 4;
    localparam int BIT_RSV_LO = 3;
    localparam int BIT_SEL_HI = 2;
    localparam int BIT_SEL_LO = 1;
    localparam int BIT_CLR    = 0;

    typedef struct packed {
        logic             flag;
        logic             ie;
        logic             run;
        logic [SEL_W-1:0] sel;
    } ctrl_t;
endpackage

// File: rtl/sit_prescaler.sv
// Module: binary prescaler counter. Counts up on adv, wraps at 2^CNT_W.
// Assumes clr has priority over adv; reset is synchronous active-low.
module sit_prescaler #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [CNT_W-1:0] cnt_q
);
    // Counter register: zero on reset or clear, else step on advance.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (adv)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sit_tap_edge.sv
// Module: selects one counter bit per the period select and flags its
// falling edge. Assumes each period log2 value is between 1 and CNT_W.
// A clear zeroes the edge history so the clear cannot look like a fall.
module sit_tap_edge
    import sit_pkg::*;
#(
    parameter int CNT_W = 15,
    parameter int P0    = 10,
    parameter int P1    = 13,
    parameter int P2    = 14,
    parameter int P3    = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] cnt,
    input  logic [SEL_W-1:0] sel,
    output logic             fall
);
    logic [NUM_SEL-1:0] taps;
    logic               tap_now;
    logic               tap_prev_q;
    logic               unused_cnt_bits;

    // One tap wire per selectable period.
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_tap
        localparam int LG = (g == 0) ? P0 : (g == 1) ? P1 : (g == 2) ? P2 : P3;
        assign taps[g] = cnt[LG-1];
    end

    assign unused_cnt_bits = ^cnt;
    assign tap_now = taps[sel];
    assign fall    = tap_prev_q & ~tap_now;

    // Edge history: previous tap value, forced low on reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            tap_prev_q <= 1'b0;
        else
            tap_prev_q <= tap_now;
    end
endmodule

// File: rtl/sit_ctrl_reg.sv
// Module: control register with flag set/acknowledge and clear strobe.
// Assumes a hardware set beats a software acknowledge in the same cycle.
module sit_ctrl_reg
    import sit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             hw_set,
    output ctrl_t            ctrl_q,
    output logic             clr_req
);
    logic unused_rsv;

    assign unused_rsv = ^wr_data[BIT_RSV_HI:BIT_RSV_LO];
    // Counter clear strobe: a written 0 in the clear position.
    assign clr_req = wr_en & ~wr_data[BIT_CLR];

    // Flag: set by hardware, acknowledged by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q.flag <= 1'b0;
        else if (hw_set)
            ctrl_q.flag <= 1'b1;
        else if (wr_en && !wr_data[BIT_FLAG])
            ctrl_q.flag <= 1'b0;
    end

    // Plain read/write fields: enable, run and period select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.ie  <= 1'b0;
            ctrl_q.run <= 1'b0;
            ctrl_q.sel <= '0;
        end else if (wr_en) begin
            ctrl_q.ie  <= wr_data[BIT_IE];
            ctrl_q.run <= wr_data[BIT_RUN];
            ctrl_q.sel <= wr_data[BIT_SEL_HI:BIT_SEL_LO];
        end
    end
endmodule

// File: rtl/subclk_interval_timer.sv
// Module: top of the sub-clock interval timer. Joins the control register,
// prescaler and tap edge detector. Assumes tick is one system cycle wide.
module subclk_interval_timer
    import sit_pkg::*;
#(
    parameter int CNT_W = 15,
    parameter int P0    = 10,
    parameter int P1    = 13,
    parameter int P2    = 14,
    parameter int P3    = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wdog_rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             irq
);
    ctrl_t            ctrl_q;
    logic             clr_req;
    logic             cnt_clr;
    logic             fall_w;
    logic [CNT_W-1:0] cnt_q;

    assign cnt_clr = clr_req | wdog_rst;

    sit_ctrl_reg i_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .hw_set  (fall_w),
        .ctrl_q  (ctrl_q),
        .clr_req (clr_req)
    );

    sit_prescaler #(.CNT_W(CNT_W)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .adv   (tick & ctrl_q.run),
        .cnt_q (cnt_q)
    );

    sit_tap_edge #(.CNT_W(CNT_W), .P0(P0), .P1(P1), .P2(P2), .P3(P3)) i_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .cnt   (cnt_q),
        .sel   (ctrl_q.sel),
        .fall  (fall_w)
    );

    // Read view: reserved bits zero, clear bit constant one.
    always_comb begin
        rd_data                         = '0;
        rd_data[BIT_FLAG]               = ctrl_q.flag;
        rd_data[BIT_IE]                 = ctrl_q.ie;
        rd_data[BIT_RUN]                = ctrl_q.run;
        rd_data[BIT_SEL_HI:BIT_SEL_LO]  = ctrl_q.sel;
        rd_data[BIT_CLR]                = 1'b1;
    end

    assign irq = ctrl_q.flag & ctrl_q.ie;
endmodule

// File: rtl/sit_checker.sv
// Module: assertion checker bound to the interval timer top.
module sit_checker #(
    parameter int CNT_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wdog_rst,
    input logic             wr_en,
    input logic [7:0]       wr_data,
    input logic [7:0]       rd_data,
    input logic             irq,
    input logic [CNT_W-1:0] cnt,
    input logic             fall
);
    AST_IRQ_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rd_data[7] && rd_data[6])); // R6
    AST_BOTH_GIVES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] && rd_data[6]) |-> irq); // R6
    AST_RUN_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[5] && !wdog_rst && !(wr_en && !wr_data[0])) |=> $stable(cnt)); // R3
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] && !(wr_en && !wr_data[7])) |=> rd_data[7]); // R5
    AST_WRITE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[0]) |=> (cnt == '0)); // R7
    AST_WDOG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |=> (cnt == '0)); // R8
    AST_WDOG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wdog_rst && !wr_en && !fall) |=> $stable(rd_data)); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> rd_data[7]); // R9
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (wdog_rst || (wr_en && !wr_data[0])) |=> !fall); // R10
endmodule

bind subclk_interval_timer sit_checker #(.CNT_W(CNT_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wdog_rst (wdog_rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .irq      (irq),
    .cnt      (cnt_q),
    .fall     (fall_w)
);

// File: tb/test_subclk_interval_timer.sv
module test_subclk_interval_timer;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wdog_rst = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    sparse = 1'b0;
    bit    tick_on = 1'b0;
    string phase = "R1";

    // Behavioural reference state.
    int m_cnt = 0, m_prev = 0, m_flag = 0, m_ie = 0, m_run = 0, m_sel = 0;
    int lg [4] = '{10, 13, 14, 15};

    subclk_interval_timer i_subclk_interval_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wdog_rst(wdog_rst),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int tapbit(int c, int s);
        return (c >> (lg[s] - 1)) & 1;
    endfunction

    function automatic logic [7:0] m_rd();
        return {m_flag[0], m_ie[0], m_run[0], 2'b00, m_sel[1:0], 1'b1};
    endfunction

    // Reference model update at each edge.
    always @(posedge clk) begin
        int tb;
        bit clr;
        if (!rst_n) begin
            m_cnt = 0; m_prev = 0; m_flag = 0; m_ie = 0; m_run = 0; m_sel = 0;
        end else begin
            tb  = tapbit(m_cnt, m_sel);
            clr = wdog_rst || (wr_en && !wr_data[0]);
            if (m_prev == 1 && tb == 0) m_flag = 1;
            else if (wr_en && !wr_data[7]) m_flag = 0;
            m_prev = clr ? 0 : tb;
            if (clr) m_cnt = 0;
            else if (m_run == 1 && tick) m_cnt = (m_cnt + 1) % 32768;
            if (wr_en) begin
                m_ie = wr_data[6]; m_run = wr_data[5]; m_sel = wr_data[2:1];
            end
        end
    end

    task automatic chk(string req, bit ok, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, tagged with the current phase.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk(phase, rd_data == m_rd(), rd_data, m_rd());
            chk(phase, irq == (m_flag[0] & m_ie[0]), irq, m_flag[0] & m_ie[0]);
        end
        tick <= tick_on && (!sparse || (cycles % 4 == 0));
        if (cycles > WDOG_LIMIT) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WDOG_LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk("R1", rd_data == 8'h01, rd_data, 8'h01);
        chk("R1", irq == 1'b0, irq, 0);

        phase = "R2";
        wr(8'h7D);
        chk("R2", rd_data == 8'h65, rd_data, 8'h65);

        phase = "R4";
        tick_on = 1'b1;
        wr(8'h21);
        idle(1100);
        chk("R4", rd_data[7] == 1'b1, rd_data[7], 1);

        phase = "R5";
        wr(8'hA1);
        chk("R5", rd_data[7] == 1'b1, rd_data[7], 1);
        wr(8'h21);
        chk("R5", rd_data[7] == 1'b0, rd_data[7], 0);

        phase = "R6";
        while (rd_data[7] == 1'b0) @(negedge clk);
        chk("R6", irq == 1'b0, irq, 0);
        wr(8'hE1);
        chk("R6", irq == 1'b1, irq, 1);
        wr(8'h61);
        chk("R6", irq == 1'b0, irq, 0);

        phase = "R9";
        @(negedge clk);
        while (!(m_prev == 1 && tapbit(m_cnt, m_sel) == 0)) @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h61;
        @(negedge clk); wr_en = 1'b0;
        chk("R9", rd_data[7] == 1'b1, rd_data[7], 1);

        phase = "R10";
        wr(8'h61);
        while (tapbit(m_cnt, m_sel) == 0) @(negedge clk);
        wr(8'h60);
        idle(1000);
        chk("R10", rd_data[7] == 1'b0, rd_data[7], 0);
        phase = "R7";
        idle(40);
        chk("R7", rd_data[7] == 1'b1, rd_data[7], 1);

        phase = "R3";
        wr(8'h41);
        idle(3000);
        chk("R3", rd_data[7] == 1'b0, rd_data[7], 0);
        wr(8'h61);

        phase = "R8";
        while (tapbit(m_cnt, m_sel) == 0) @(negedge clk);
        wdog_rst = 1'b1;
        @(negedge clk); wdog_rst = 1'b0;
        chk("R8", rd_data == 8'h61, rd_data, 8'h61);
        idle(1000);
        chk("R8", rd_data[7] == 1'b0, rd_data[7], 0);

        phase = "R3";
        sparse = 1'b1;
        wr(8'h60);
        idle(4000);
        chk("R3", rd_data[7] == 1'b0, rd_data[7], 0);
        idle(200);
        chk("R3", rd_data[7] == 1'b1, rd_data[7], 1);
        sparse = 1'b0;

        phase = "R4";
        wr(8'h62);
        idle(8100);
        chk("R4", rd_data[7] == 1'b0, rd_data[7], 0);
        idle(200);
        chk("R4", rd_data[7] == 1'b1, rd_data[7], 1);
        wr(8'h64);
        idle(16300);
        chk("R4", rd_data[7] == 1'b0, rd_data[7], 0);
        idle(200);
        chk("R4", rd_data[7] == 1'b1, rd_data[7], 1);
        wr(8'h66);
        idle(32700);
        chk("R4", rd_data[7] == 1'b0, rd_data[7], 0);
        idle(200);
        chk("R4", rd_data[7] == 1'b1, rd_data[7], 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule